// File: doc/BRIEF.md
# Track Format Byte Encoder

This block turns a stream of host bytes into the byte slots of a whole-track format write. A command pulse arms it and raises a data request. The host loads the first byte into a one-byte holding register. Writing opens at the next rising edge of the index signal and closes at the following one. On every byte-time tick during the write, the block consumes the held byte and presents one data/clock byte pair to a downstream serializer. It then asks the host for the next byte.

Host values F5 through FE are control codes, and their meaning depends on the density select. They produce address marks with a missing clock and preset the running CRC. The value F7 makes the block insert the two CRC bytes. If the host falls behind, the block writes a zero byte and flags lost data. If no first byte arrives, the block aborts the command.

Top module: `fmt_track_encoder`

## Requirements
- R1: A `start` pulse while idle sets `busy` and `data_req` and clears `irq`, `lost_data` and the CRC (to FFFF). A `start` pulse while busy is ignored, and `host_wr` while idle is ignored.
- R2: Before the first byte is loaded, the third `byte_tick` with the holding register still empty ends the command. On that edge `busy` and `data_req` go low and `lost_data` and `irq` go high.
- R3: Once the first byte is loaded, `data_req` drops and `write_gate` rises at the next rising edge of `index_pulse`. Index edges seen before the first load are ignored, and no byte is emitted before the gate opens.
- R4: With the gate open, each `byte_tick` gives one cycle of `out_valid` on the following edge. The held byte is consumed and `data_req` rises again, except as R9 states.
- R5: A tick that finds the holding register empty emits data 00 with clock FF and sets `lost_data`. Writing continues.
- R6: A rising edge of `index_pulse` during the write ends the command. `write_gate`, `busy` and `data_req` go low and `irq` goes high. A tick on that same cycle emits nothing.
- R7: In MFM mode (`mfm_mode`=1), host F5 emits data A1 with clock mask FB and presets the CRC. Host F6 emits data C2 with clock mask F7.
- R8: In FM mode, host F8..FE is emitted unchanged with clock C7, except FC, which uses D7, and each presets the CRC. In MFM mode, F8..FE use clock FF. In FM mode, F5 and F6 use clock FF. Every other non-F7 value uses clock FF.
- R9: Host F7 emits the CRC high byte in its slot and the CRC low byte in the next slot, both with clock FF. `data_req` stays low until the low byte has gone out.
- R10: The CRC is CRC-16 (polynomial 1021 hex), taken MSB first. A preset byte is folded into FFFF. Every other emitted data byte, substituted zeros included, is folded into the running value. The CRC bytes themselves are not folded in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse |
| mfm_mode | input | 1 | 1 = MFM density, 0 = FM |
| index_pulse | input | 1 | Index sensor level |
| byte_tick | input | 1 | One-cycle pulse per byte time |
| host_wr | input | 1 | Host write strobe to the holding register |
| host_data | input | 8 | Host byte |
| data_req | output | 1 | Holding register wants a byte |
| out_valid | output | 1 | Byte slot strobe |
| out_data | output | 8 | Data byte for the serializer |
| out_clock | output | 8 | Clock mask for the serializer (FF = all clocks) |
| write_gate | output | 1 | Write window open |
| busy | output | 1 | Command active |
| lost_data | output | 1 | Host underrun or first-byte timeout |
| irq | output | 1 | Command finished |

## Verification
All status outputs (`busy`, `data_req`, `write_gate`, `lost_data`, `irq`) change on the clock edge that samples the causing input. The byte pair with `out_valid` appears on the edge that samples `byte_tick`, which is one cycle after the tick is driven. The bench drives inputs and samples outputs on falling edges. Its behavioural model advances on the same rising edges as the design, so every output is compared each cycle exactly where it becomes due. Byte comparisons carry the tag of the rule that produced the expected value.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_WAIT_IDX, ST_WRITE} fmt_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] clk;
    logic       preset;
    logic       crc_emit;
  } fmt_sym_t;

  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [7:0]  CLK_ALL    = 8'hFF;
  localparam logic [7:0]  CLK_FM_MK  = 8'hC7;
  localparam logic [7:0]  CLK_FM_FC  = 8'hD7;
  localparam logic [7:0]  CLK_MFM_A1 = 8'hFB;
  localparam logic [7:0]  CLK_MFM_C2 = 8'hF7;

  // Bitwise feedback form, MSB of the byte first.
  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  // Map a host byte to the symbol written in its slot.
  function automatic fmt_sym_t classify(logic [7:0] b, logic mfm);
    fmt_sym_t s;
    s.data     = b;
    s.clk      = CLK_ALL;
    s.preset   = 1'b0;
    s.crc_emit = 1'b0;
    if (b == 8'hF7) begin
      s.crc_emit = 1'b1;
    end else if (mfm) begin
      if (b == 8'hF5) begin
        s.data   = 8'hA1;
        s.clk    = CLK_MFM_A1;
        s.preset = 1'b1;
      end else if (b == 8'hF6) begin
        s.data = 8'hC2;
        s.clk  = CLK_MFM_C2;
      end
    end else if (b >= 8'hF8 && b <= 8'hFE) begin
      s.preset = 1'b1;
      s.clk    = (b == 8'hFC) ? CLK_FM_FC : CLK_FM_MK;
    end
    return s;
  endfunction

endpackage

// File: rtl/fmt_edge.sv
`timescale 1ns/1ps
module fmt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/fmt_decode.sv
`timescale 1ns/1ps
module fmt_decode
  import fmt_pkg::*;
(
  input  logic [7:0] host_byte,
  input  logic       mfm,
  output fmt_sym_t   sym
);
  always_comb sym = classify(host_byte, mfm);
endmodule

// File: rtl/fmt_crc.sv
`timescale 1ns/1ps
module fmt_crc
  import fmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        feed,
  input  logic        preset,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q;
  logic [15:0] base;

  assign base = preset ? CRC_INIT : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_INIT;
    else if (init) crc_q <= CRC_INIT;
    else if (feed) crc_q <= crc_byte(base, din);
  end

  assign crc = crc_q;
endmodule

// File: rtl/fmt_track_encoder.sv
`timescale 1ns/1ps
module fmt_track_encoder
  import fmt_pkg::*;
#(
  parameter int ABORT_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mfm_mode,
  input  logic       index_pulse,
  input  logic       byte_tick,
  input  logic       host_wr,
  input  logic [7:0] host_data,
  output logic       data_req,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic [7:0] out_clock,
  output logic       write_gate,
  output logic       busy,
  output logic       lost_data,
  output logic       irq
);
  localparam int CW = $clog2(ABORT_TICKS + 1);

  fmt_state_e  state_q;
  logic        full_q, c2_q, ov_q, irq_q, lost_q;
  logic [7:0]  hold_q, od_q, oc_q;
  logic [CW-1:0] wait_q;
  logic        idx_rise;
  fmt_sym_t    sym;
  logic [15:0] crc;

  // Named internal events.
  logic start_ev, load_ev, abort_ev, open_ev, end_ev, slot_ev;
  logic crc_lo_ev, take_ev, underrun_ev, crc_hi_ev;
  logic crc_feed, crc_preset;
  logic [7:0] crc_din;

  fmt_edge u_edge (.clk(clk), .rst_n(rst_n), .level(index_pulse), .rise(idx_rise));
  fmt_decode u_dec (.host_byte(hold_q), .mfm(mfm_mode), .sym(sym));

  assign start_ev    = start && state_q == ST_IDLE;
  assign load_ev     = host_wr && state_q != ST_IDLE;
  assign abort_ev    = state_q == ST_ARM && !host_wr && byte_tick &&
                       wait_q == CW'(ABORT_TICKS - 1);
  assign open_ev     = state_q == ST_WAIT_IDX && idx_rise;
  assign end_ev      = state_q == ST_WRITE && idx_rise;
  assign slot_ev     = state_q == ST_WRITE && byte_tick && !idx_rise;
  assign crc_lo_ev   = slot_ev && c2_q;
  assign take_ev     = slot_ev && !c2_q && full_q;
  assign underrun_ev = slot_ev && !c2_q && !full_q;
  assign crc_hi_ev   = take_ev && sym.crc_emit;

  assign crc_feed   = (take_ev && !sym.crc_emit) || underrun_ev;
  assign crc_preset = take_ev && sym.preset;
  assign crc_din    = underrun_ev ? 8'h00 : sym.data;

  fmt_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(start_ev), .feed(crc_feed),
    .preset(crc_preset), .din(crc_din), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
      hold_q  <= 8'h00;
      c2_q    <= 1'b0;
      wait_q  <= '0;
      ov_q    <= 1'b0;
      od_q    <= 8'h00;
      oc_q    <= 8'h00;
      irq_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      ov_q <= slot_ev;
      if (crc_lo_ev) begin
        od_q <= crc[7:0];
        oc_q <= CLK_ALL;
      end else if (crc_hi_ev) begin
        od_q <= crc[15:8];
        oc_q <= CLK_ALL;
      end else if (take_ev) begin
        od_q <= sym.data;
        oc_q <= sym.clk;
      end else if (underrun_ev) begin
        od_q <= 8'h00;
        oc_q <= CLK_ALL;
      end

      if (start_ev || crc_lo_ev) c2_q <= 1'b0;
      else if (crc_hi_ev)        c2_q <= 1'b1;

      if (start_ev)     full_q <= 1'b0;
      else if (load_ev) full_q <= 1'b1;
      else if (take_ev) full_q <= 1'b0;

      if (load_ev) hold_q <= host_data;

      if (start_ev)                            wait_q <= '0;
      else if (state_q == ST_ARM && byte_tick) wait_q <= wait_q + 1'b1;

      if (start_ev)                      lost_q <= 1'b0;
      else if (abort_ev || underrun_ev)  lost_q <= 1'b1;

      if (start_ev)                irq_q <= 1'b0;
      else if (abort_ev || end_ev) irq_q <= 1'b1;

      unique case (state_q)
        ST_IDLE:     if (start_ev) state_q <= ST_ARM;
        ST_ARM:      if (host_wr) state_q <= ST_WAIT_IDX;
                     else if (abort_ev) state_q <= ST_IDLE;
        ST_WAIT_IDX: if (open_ev) state_q <= ST_WRITE;
        ST_WRITE:    if (end_ev) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = state_q != ST_IDLE;
  assign write_gate = state_q == ST_WRITE;
  assign data_req   = busy && !full_q && !c2_q;
  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign out_clock  = oc_q;
  assign irq        = irq_q;
  assign lost_data  = lost_q;

  // Assertions next to the logic they guard.
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy && data_req && !irq && !lost_data);

  assert_abort_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !busy && !data_req && lost_data && irq);

  assert_gate_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_ev |=> write_gate && !data_req);

  assert_emit_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(write_gate));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_ev |=> out_valid && out_data == 8'h00 && out_clock == 8'hFF && lost_data);

  assert_irq_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy && !write_gate);

  assert_mfm_a1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && mfm_mode && hold_q == 8'hF5) |=> out_data == 8'hA1 && out_clock == 8'hFB);

  assert_crc_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    crc_hi_ev |=> c2_q && !data_req && out_clock == 8'hFF);

  assert_crc_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    crc_lo_ev |=> out_valid && out_data == $past(crc[7:0]));
endmodule

// File: tb/fmt_track_encoder_bench.sv
`timescale 1ns/1ps
module fmt_track_encoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mfm_mode = 1'b0, index_pulse = 1'b0, byte_tick = 1'b0, host_wr = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic data_req, out_valid, write_gate, busy, lost_data, irq;
  logic [7:0] out_data, out_clock;

  always #2.5 clk = ~clk;

  fmt_track_encoder u_fmt_track_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .mfm_mode(mfm_mode),
    .index_pulse(index_pulse), .byte_tick(byte_tick), .host_wr(host_wr),
    .host_data(host_data), .data_req(data_req), .out_valid(out_valid),
    .out_data(out_data), .out_clock(out_clock), .write_gate(write_gate),
    .busy(busy), .lost_data(lost_data), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int m_state = 0, m_wait = 0;   // 0 idle, 1 waiting first byte, 2 waiting index, 3 writing
  bit m_full = 0, m_c2 = 0, m_prev = 0, m_irq = 0, m_lost = 0, m_ov = 0;
  logic [7:0] m_hold = 0, m_od = 0, m_oc = 0;
  logic [15:0] m_crc = 16'hFFFF;
  string m_tag = "R4";

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic model_slot();
    logic [7:0] b;
    m_ov = 1;
    if (m_c2) begin
      m_od = m_crc[7:0]; m_oc = 8'hFF; m_c2 = 0; m_tag = "R9 R10";
    end else if (m_full) begin
      m_full = 0; b = m_hold;
      if (b == 8'hF7) begin
        m_od = m_crc[15:8]; m_oc = 8'hFF; m_c2 = 1; m_tag = "R9 R10";
      end else if (mfm_mode && b == 8'hF5) begin
        m_od = 8'hA1; m_oc = 8'hFB; m_crc = ref_crc(16'hFFFF, 8'hA1); m_tag = "R7";
      end else if (mfm_mode && b == 8'hF6) begin
        m_od = 8'hC2; m_oc = 8'hF7; m_crc = ref_crc(m_crc, 8'hC2); m_tag = "R7";
      end else if (!mfm_mode && b >= 8'hF8 && b <= 8'hFE) begin
        m_od = b; m_oc = (b == 8'hFC) ? 8'hD7 : 8'hC7; m_crc = ref_crc(16'hFFFF, b); m_tag = "R8";
      end else begin
        m_od = b; m_oc = 8'hFF; m_crc = ref_crc(m_crc, b);
        m_tag = (b >= 8'hF5 && b <= 8'hFE) ? "R8" : "R4";
      end
    end else begin
      m_od = 8'h00; m_oc = 8'hFF; m_lost = 1; m_crc = ref_crc(m_crc, 8'h00); m_tag = "R5";
    end
  endtask

  always @(posedge clk) begin
    bit rise;
    if (!rst_n) begin
      m_state = 0; m_wait = 0; m_full = 0; m_c2 = 0; m_prev = 0; m_irq = 0;
      m_lost = 0; m_ov = 0; m_hold = 0; m_od = 0; m_oc = 0; m_crc = 16'hFFFF;
    end else begin
      rise = index_pulse && !m_prev;
      m_prev = index_pulse;
      m_ov = 0;
      case (m_state)
        0: if (start) begin
             m_state = 1; m_irq = 0; m_lost = 0; m_full = 0; m_wait = 0; m_c2 = 0; m_crc = 16'hFFFF;
           end
        1: if (host_wr) begin
             m_full = 1; m_hold = host_data; m_state = 2;
           end else if (byte_tick) begin
             m_wait++;
             if (m_wait == 3) begin m_state = 0; m_lost = 1; m_irq = 1; end
           end
        2: begin
             if (host_wr) m_hold = host_data;
             if (rise) m_state = 3;
           end
        default: if (rise) begin
             m_state = 0; m_irq = 1;
           end else begin
             if (byte_tick) model_slot();
             if (host_wr) begin m_full = 1; m_hold = host_data; end
           end
      endcase
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6", "busy", {7'd0, busy}, {7'd0, m_state != 0});
      check("R3", "write_gate", {7'd0, write_gate}, {7'd0, m_state == 3});
      check("R9", "data_req", {7'd0, data_req}, {7'd0, m_state != 0 && !m_full && !m_c2});
      check("R5", "lost_data", {7'd0, lost_data}, {7'd0, m_lost});
      check("R2", "irq", {7'd0, irq}, {7'd0, m_irq});
      check("R4", "out_valid", {7'd0, out_valid}, {7'd0, m_ov});
      if (m_ov) begin
        check(m_tag, "out_data", out_data, m_od);
        check(m_tag, "out_clock", out_clock, m_oc);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic tick(); @(negedge clk) byte_tick = 1; @(negedge clk) byte_tick = 0; endtask
  task automatic wr(logic [7:0] b);
    @(negedge clk) begin host_wr = 1; host_data = b; end
    @(negedge clk) host_wr = 0;
  endtask
  task automatic pulse_start(); @(negedge clk) start = 1; @(negedge clk) start = 0; endtask
  task automatic index_edge(); @(negedge clk) index_pulse = 1; cyc(2); index_pulse = 0; endtask
  task automatic slot(logic [8:0] e);   // e[8] = host supplies e[7:0] after this slot
    tick(); cyc(1);
    if (e[8]) wr(e[7:0]);
    cyc(1);
  endtask
  task automatic end_with_tick();   // R6: index edge and tick on the same cycle
    @(negedge clk) begin index_pulse = 1; byte_tick = 1; end
    @(negedge clk) byte_tick = 0;
    cyc(2); index_pulse = 0; cyc(2);
  endtask

  localparam logic [8:0] SEQ_M [18] = '{
    9'h100, 9'h1F5, 9'h1F5, 9'h1F5, 9'h1FE, 9'h101, 9'h102, 9'h1F7, 9'h000,
    9'h14E, 9'h000, 9'h1F6, 9'h1F8, 9'h1FC, 9'h1F7, 9'h000, 9'h133, 9'h000};
  localparam logic [8:0] SEQ_F [16] = '{
    9'h1FF, 9'h1FE, 9'h101, 9'h1F5, 9'h1F6, 9'h1F7, 9'h000, 9'h1FC, 9'h1FB,
    9'h1F8, 9'h1FD, 9'h1F7, 9'h000, 9'h000, 9'h1E5, 9'h000};

  initial begin
    cyc(4);
    rst_n = 1;
    cyc(1);
    check("R1", "reset busy", {7'd0, busy}, 8'd0);
    check("R1", "reset data_req", {7'd0, data_req}, 8'd0);
    // R1: host write while idle must not fill the register (data_req stays 1 after start).
    wr(8'h55);
    pulse_start();
    cyc(1);
    check("R1", "data_req after start", {7'd0, data_req}, 8'd1);
    // R3: index edge before first load is ignored; R2: timeout after three ticks.
    index_edge();
    check("R3", "gate before load", {7'd0, write_gate}, 8'd0);
    tick(); cyc(2); tick(); cyc(2); tick(); cyc(2);
    check("R2", "lost after timeout", {7'd0, lost_data}, 8'd1);

    // MFM track
    mfm_mode = 1;
    pulse_start();
    wr(8'h4E);
    cyc(3);
    check("R3", "gate waits for index", {7'd0, write_gate}, 8'd0);
    index_edge();
    for (int i = 0; i < 18; i++) begin
      slot(SEQ_M[i]);
      if (i == 5) pulse_start();   // R1: ignored while busy
    end
    index_edge();
    cyc(3);
    check("R6", "irq at end", {7'd0, irq}, 8'd1);

    // FM track
    mfm_mode = 0;
    pulse_start();
    wr(8'h00);
    index_edge();
    foreach (SEQ_F[i]) slot(SEQ_F[i]);
    end_with_tick();
    check("R6", "idle after end", {7'd0, busy}, 8'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule